// File: doc/BRIEF.md
# Serial Frame Controller for a Six-Channel Output Driver

This block is the device side of a 16-bit serial link. A host uses it to set six output channels and to read their diagnostic status. The serial clock, data-in and active-low select pins are sampled by a fast system clock through two-flop synchronizers. Every serial event is then handled as an edge in the system clock domain. The system clock must run at least four times faster than the serial clock, and the serial clock is at most 5 MHz.

When select falls, the block copies a 16-bit diagnostic word into a transmit register and starts to drive the serial output. Incoming bits are shifted in most significant bit first, on falling serial-clock edges. The first byte is an instruction and the second byte is data. When select rises, the block commits the frame only if all of these hold:

- exactly sixteen falling serial-clock edges were seen;
- the serial clock was low at both select edges;
- the instruction addresses this device.

A committed read command gives a one-cycle read strobe, which lets the diagnostic source clear its latched faults. A committed write command gives a one-cycle write strobe together with six new channel bits.

Top module: `spi_frame_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it is released with select high, `so_oe`, `ctrl_we` and `rd_diag_pulse` are 0 and `ctrl_bits` is 0. A reset during a frame discards that frame.
- R2: On the falling edge of select, `diag_word` is captured. `so_out` presents bit 15 first. It moves to the next lower bit on each rising serial-clock edge from the second one on, so a host sampling on falling edges receives the word most significant bit first.
- R3: Serial input is sampled on falling serial-clock edges, most significant bit first. Frame bits 15:8 are the instruction and bits 7:0 are the data byte.
- R4: A frame with 15, 17 or any count other than exactly 16 falling serial-clock edges commits nothing. A falling serial-clock edge that lands in the same sampled cycle as the rising edge of select is not counted.
- R5: The device is addressed only when frame bits 15:14 are 2'b10. Otherwise nothing is committed, and `so_oe` returns to 0 once the second bit has been received.
- R6: Frame bits 13:8 select the command. 6'b000001 gives a one-cycle `rd_diag_pulse`. 6'b000010 gives a one-cycle `ctrl_we`, with `ctrl_bits` set to frame bits 5:0, and frame bits 7:6 have no effect. Any other value commits nothing.
- R7: If the serial clock is high at the falling or the rising edge of select, the frame is discarded.
- R8: While select is high, serial-clock and data activity produces no strobe and leaves `ctrl_bits` unchanged.
- R9: `so_oe` is 0 whenever select has been high for the two synchronizer cycles.
- R10: `ctrl_we` and `rd_diag_pulse` are never high together. Each lasts one cycle. `ctrl_bits` changes only in a cycle where `ctrl_we` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk_in | input | 1 | Serial clock from host, asynchronous |
| si_in | input | 1 | Serial data from host, asynchronous |
| cs_n_in | input | 1 | Active-low select from host, asynchronous |
| diag_word | input | 16 | Diagnostic status captured at select fall |
| so_out | output | 1 | Serial data to host |
| so_oe | output | 1 | Output enable for the serial data pad (0 = high impedance) |
| ctrl_we | output | 1 | One-cycle strobe for a committed write |
| ctrl_bits | output | 6 | Channel control bits from the last committed write |
| rd_diag_pulse | output | 1 | One-cycle strobe for a committed diagnostic read |

## Verification
Two events can land in the same sampled system cycle: the last falling serial-clock edge and the rising edge of select. In that cycle the frame commit wins and the shift is lost. The bench provokes this by driving the sixteenth falling edge and the select release on the same clock. It expects no strobe and unchanged `ctrl_bits`, because only fifteen edges were counted. A related case has a reset arriving in the middle of a frame while select stays low. The bench checks that the frame restarts from zero and that the later release of select commits nothing.

// File: rtl/spi_frame_pkg.sv
// Shared constants and types for the serial frame controller.
// Assumes the 16-bit frame layout: select(2) | command(6) | data(8).
package spi_frame_pkg;
    localparam int SEL_W = 2;
    localparam int CMD_W = 6;
    localparam logic [SEL_W-1:0] SEL_MATCH = 2'b10;
    localparam logic [CMD_W-1:0] CMD_READ_DIAG = 6'b000001;
    localparam logic [CMD_W-1:0] CMD_WRITE_CTRL = 6'b000010;

    typedef enum logic [1:0] {
        ACT_NONE  = 2'd0,
        ACT_READ  = 2'd1,
        ACT_WRITE = 2'd2
    } frame_act_e;
endpackage

// File: rtl/spi_in_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous single-bit inputs.
// Assumes each bit is independent; RST_VAL sets each bit's idle level.
module spi_in_sync #(
    parameter int W = 3,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [STAGES-1:0][W-1:0] pipe;

    // Shift the raw inputs through the synchronizer stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe <= {STAGES{RST_VAL}};
        end else begin
            pipe[0] <= d_async;
            for (int s = 1; s < STAGES; s++) begin
                pipe[s] <= pipe[s-1];
            end
        end
    end

    assign q_sync = pipe[STAGES-1];
endmodule

// File: rtl/spi_shift_core.sv
// Receive/transmit shift registers, edge counter and select-field check.
// Assumes edge strobes are single-cycle and mutually exclusive for the serial clock.
module spi_shift_core #(
    parameter int FRAME_W = 16,
    parameter int CH_W = 6,
    localparam int CNT_W = $clog2(FRAME_W + 2),
    localparam int BYTE_W = FRAME_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act,
    input  logic              cs_start,
    input  logic              sclk_lvl,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              si_lvl,
    input  logic [FRAME_W-1:0] diag_word,
    output logic [BYTE_W-1:0] instr_byte,
    output logic [CH_W-1:0]   ch_field,
    output logic [CNT_W-1:0]  bit_cnt,
    output logic              edge_err,
    output logic              sel_bad,
    output logic              so_bit
);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FRAME_W + 1);

    logic [FRAME_W-1:0] rx_sr;
    logic [FRAME_W-1:0] tx_sr;

    // Frame start loads the snapshot; serial edges shift while select is active.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_sr    <= '0;
            tx_sr    <= '0;
            bit_cnt  <= '0;
            edge_err <= 1'b0;
            sel_bad  <= 1'b0;
        end else if (cs_start) begin
            rx_sr    <= '0;
            tx_sr    <= diag_word;
            bit_cnt  <= '0;
            edge_err <= sclk_lvl;
            sel_bad  <= 1'b0;
        end else if (cs_act) begin
            if (sclk_fall) begin
                rx_sr <= {rx_sr[FRAME_W-2:0], si_lvl};
                if (bit_cnt != CNT_MAX) begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
                if (bit_cnt == CNT_W'(1)) begin
                    sel_bad <= !(rx_sr[0] && !si_lvl);
                end
            end
            if (sclk_rise && bit_cnt != '0) begin
                tx_sr <= {tx_sr[FRAME_W-2:0], 1'b0};
            end
        end
    end

    assign instr_byte = rx_sr[FRAME_W-1 -: BYTE_W];
    assign ch_field   = rx_sr[CH_W-1:0];
    assign so_bit     = tx_sr[FRAME_W-1];
endmodule

// File: rtl/spi_cmd_decode.sv
// Frame validation at select release and decoding into single-cycle strobes.
// Assumes commit_evt is a one-cycle strobe at the rising edge of select.
module spi_cmd_decode
    import spi_frame_pkg::*;
#(
    parameter int FRAME_W = 16,
    parameter int CH_W = 6,
    localparam int CNT_W = $clog2(FRAME_W + 2),
    localparam int BYTE_W = FRAME_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit_evt,
    input  logic [CNT_W-1:0]  bit_cnt,
    input  logic              edge_err,
    input  logic              sclk_lvl,
    input  logic [BYTE_W-1:0] instr_byte,
    input  logic [CH_W-1:0]   ch_field,
    output logic              ctrl_we,
    output logic [CH_W-1:0]   ctrl_bits,
    output logic              rd_diag_pulse
);
    frame_act_e act;
    logic       frame_ok;

    // Qualify the frame: exact count, clean select edges, device addressed.
    always_comb begin
        frame_ok = commit_evt && (bit_cnt == CNT_W'(FRAME_W)) && !edge_err && !sclk_lvl
                   && (instr_byte[BYTE_W-1 -: SEL_W] == SEL_MATCH);
        act = ACT_NONE;
        if (frame_ok) begin
            case (instr_byte[CMD_W-1:0])
                CMD_READ_DIAG:  act = ACT_READ;
                CMD_WRITE_CTRL: act = ACT_WRITE;
                default:        act = ACT_NONE;
            endcase
        end
    end

    // Register the strobes and the channel bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_we       <= 1'b0;
            rd_diag_pulse <= 1'b0;
            ctrl_bits     <= '0;
        end else begin
            ctrl_we       <= (act == ACT_WRITE);
            rd_diag_pulse <= (act == ACT_READ);
            if (act == ACT_WRITE) begin
                ctrl_bits <= ch_field;
            end
        end
    end
endmodule

// File: rtl/spi_frame_ctrl.sv
// Top: serial slave frame controller for a six-channel driver.
// Assumes clk >= 4x the serial clock; pins are asynchronous to clk.
module spi_frame_ctrl #(
    parameter int FRAME_W = 16,
    parameter int CH_W = 6,
    parameter int SYNC_STAGES = 2,
    localparam int CNT_W = $clog2(FRAME_W + 2),
    localparam int BYTE_W = FRAME_W / 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk_in,
    input  logic               si_in,
    input  logic               cs_n_in,
    input  logic [FRAME_W-1:0] diag_word,
    output logic               so_out,
    output logic               so_oe,
    output logic               ctrl_we,
    output logic [CH_W-1:0]    ctrl_bits,
    output logic               rd_diag_pulse
);
    logic [2:0]        pins_sync;
    logic              sclk_lvl, si_lvl, cs_n_lvl;
    logic              sclk_prev, cs_n_prev;
    logic              sclk_rise, sclk_fall, cs_start, cs_rise, cs_act;
    logic [BYTE_W-1:0] instr_byte;
    logic [CH_W-1:0]   ch_field;
    logic [CNT_W-1:0]  bit_cnt;
    logic              edge_err, sel_bad, so_bit;

    spi_in_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d_async({cs_n_in, si_in, sclk_in}),
        .q_sync(pins_sync)
    );

    assign sclk_lvl = pins_sync[0];
    assign si_lvl   = pins_sync[1];
    assign cs_n_lvl = pins_sync[2];

    // Hold the previous synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_prev <= 1'b0;
            cs_n_prev <= 1'b1;
        end else begin
            sclk_prev <= sclk_lvl;
            cs_n_prev <= cs_n_lvl;
        end
    end

    assign sclk_rise = sclk_lvl && !sclk_prev;
    assign sclk_fall = !sclk_lvl && sclk_prev;
    assign cs_start  = !cs_n_lvl && cs_n_prev;
    assign cs_rise   = cs_n_lvl && !cs_n_prev;
    assign cs_act    = !cs_n_lvl;

    spi_shift_core #(.FRAME_W(FRAME_W), .CH_W(CH_W)) u_shift (
        .clk(clk), .rst_n(rst_n),
        .cs_act(cs_act), .cs_start(cs_start),
        .sclk_lvl(sclk_lvl), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
        .si_lvl(si_lvl), .diag_word(diag_word),
        .instr_byte(instr_byte), .ch_field(ch_field), .bit_cnt(bit_cnt),
        .edge_err(edge_err), .sel_bad(sel_bad), .so_bit(so_bit)
    );

    spi_cmd_decode #(.FRAME_W(FRAME_W), .CH_W(CH_W)) u_dec (
        .clk(clk), .rst_n(rst_n),
        .commit_evt(cs_rise), .bit_cnt(bit_cnt), .edge_err(edge_err),
        .sclk_lvl(sclk_lvl), .instr_byte(instr_byte), .ch_field(ch_field),
        .ctrl_we(ctrl_we), .ctrl_bits(ctrl_bits), .rd_diag_pulse(rd_diag_pulse)
    );

    assign so_oe  = cs_act && !sel_bad;
    assign so_out = so_bit;
endmodule

// File: rtl/spi_frame_ctrl_chk.sv
// Protocol checker for spi_frame_ctrl, attached through bind below.
// Assumes the default two-stage synchronizer.
module spi_frame_ctrl_chk #(
    parameter int CH_W = 6,
    parameter int CNT_W = 5,
    parameter int CNT_LIM = 17
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_n_in,
    input logic             so_oe,
    input logic             ctrl_we,
    input logic             rd_diag_pulse,
    input logic [CH_W-1:0]  ctrl_bits,
    input logic             cs_rise,
    input logic [CNT_W-1:0] bit_cnt
);
    assert_strobes_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctrl_we && rd_diag_pulse));

    assert_we_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_we |=> !ctrl_we);

    assert_rd_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_diag_pulse |=> !rd_diag_pulse);

    assert_bits_only_on_we_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_bits != $past(ctrl_bits)) |-> ctrl_we);

    assert_rd_after_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_diag_pulse |-> $past(cs_rise));

    assert_we_after_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_we |-> $past(cs_rise));

    assert_oe_needs_select_R9: assert property (@(posedge clk) disable iff (!rst_n)
        so_oe |-> !$past(cs_n_in, 2));

    assert_count_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= CNT_W'(CNT_LIM));
endmodule

bind spi_frame_ctrl spi_frame_ctrl_chk #(.CH_W(CH_W), .CNT_W(CNT_W), .CNT_LIM(FRAME_W + 1)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n_in(cs_n_in), .so_oe(so_oe),
    .ctrl_we(ctrl_we), .rd_diag_pulse(rd_diag_pulse), .ctrl_bits(ctrl_bits),
    .cs_rise(cs_rise), .bit_cnt(bit_cnt)
);

// File: tb/spi_frame_ctrl_test.sv
// Self-checking bench: vector table walk, then directed corner cases.
module spi_frame_ctrl_test;
    localparam int HALF = 6;

    typedef struct packed {
        logic [7:0]  instr;
        logic [7:0]  data;
        logic [4:0]  npulse;
        logic [15:0] diag;
        logic        exp_we;
        logic        exp_rd;
        logic [5:0]  exp_bits;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VECS [NVEC] = '{
        '{8'h82, 8'h2D, 5'd16, 16'hA5C3, 1'b1, 1'b0, 6'h2D},
        '{8'h81, 8'hFF, 5'd16, 16'h1234, 1'b0, 1'b1, 6'h2D},
        '{8'h82, 8'hD2, 5'd16, 16'h8001, 1'b1, 1'b0, 6'h12},
        '{8'h42, 8'h3F, 5'd16, 16'hFFFF, 1'b0, 1'b0, 6'h12},
        '{8'h83, 8'h3F, 5'd16, 16'h5AA5, 1'b0, 1'b0, 6'h12},
        '{8'h82, 8'h3F, 5'd15, 16'h0F0F, 1'b0, 1'b0, 6'h12},
        '{8'h82, 8'h3F, 5'd17, 16'hF0F0, 1'b0, 1'b0, 6'h12},
        '{8'h82, 8'h3F, 5'd16, 16'h7E81, 1'b1, 1'b0, 6'h3F},
        '{8'hC2, 8'h00, 5'd16, 16'h0000, 1'b0, 1'b0, 6'h3F}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk_in = 1'b0;
    logic        si_in = 1'b0;
    logic        cs_n_in = 1'b1;
    logic [15:0] diag_word = '0;
    logic        so_out, so_oe, ctrl_we, rd_diag_pulse;
    logic [5:0]  ctrl_bits;

    int total = 0;
    int bad = 0;
    int we_cnt = 0;
    int rd_cnt = 0;
    logic [15:0] so_cap;
    logic        oe_late;
    logic        oe_in_rst;
    logic        done = 1'b0;

    spi_frame_ctrl uut (
        .clk(clk), .rst_n(rst_n), .sclk_in(sclk_in), .si_in(si_in), .cs_n_in(cs_n_in),
        .diag_word(diag_word), .so_out(so_out), .so_oe(so_oe), .ctrl_we(ctrl_we),
        .ctrl_bits(ctrl_bits), .rd_diag_pulse(rd_diag_pulse)
    );

    always #2 clk = ~clk;

    // Count strobes, sampled away from the active edge.
    always @(negedge clk) begin
        if (ctrl_we) we_cnt++;
        if (rd_diag_pulse) rd_cnt++;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_frame(input logic [15:0] word, input int n, input bit hi_start,
                             input bit hi_end, input bit merge_last, input int rst_after);
        @(negedge clk);
        if (hi_start) begin si_in = 1'b1; sclk_in = 1'b1; repeat (HALF) @(negedge clk); end
        cs_n_in = 1'b0;
        repeat (HALF) @(negedge clk);
        if (hi_start) begin sclk_in = 1'b0; repeat (HALF) @(negedge clk); end
        so_cap = '0;
        oe_late = 1'b0;
        for (int i = 0; i < n; i++) begin
            si_in = (i < 16) ? word[15-i] : 1'b0;
            sclk_in = 1'b1;
            repeat (HALF) @(negedge clk);
            so_cap = {so_cap[14:0], so_out};
            oe_late = so_oe;
            if (merge_last && i == n - 1) begin
                sclk_in = 1'b0;
                cs_n_in = 1'b1;
            end else begin
                sclk_in = 1'b0;
                repeat (HALF) @(negedge clk);
            end
            if (i == rst_after) begin
                rst_n = 1'b0;
                repeat (2) @(negedge clk);
                oe_in_rst = so_oe;
                @(negedge clk);
                rst_n = 1'b1;
                repeat (HALF) @(negedge clk);
            end
        end
        if (!merge_last) begin
            if (hi_end) begin sclk_in = 1'b1; repeat (HALF) @(negedge clk); end
            cs_n_in = 1'b1;
        end
        repeat (HALF) @(negedge clk);
        sclk_in = 1'b0;
        repeat (2 * HALF) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int we0, rd0;
        repeat (5) @(negedge clk);
        // R1: reset state
        check("R1 so_oe in reset", {31'd0, so_oe}, 32'd0);
        check("R1 ctrl_bits in reset", {26'd0, ctrl_bits}, 32'd0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R1 strobes after reset", {30'd0, ctrl_we, rd_diag_pulse}, 32'd0);
        check("R9 so_oe idle", {31'd0, so_oe}, 32'd0);

        // Table walk: R2 R3 R4 R5 R6
        for (int v = 0; v < NVEC; v++) begin
            diag_word = VECS[v].diag;
            we0 = we_cnt;
            rd0 = rd_cnt;
            run_frame({VECS[v].instr, VECS[v].data}, int'(VECS[v].npulse), 1'b0, 1'b0, 1'b0, -1);
            check($sformatf("R6 write strobes vec%0d", v), we_cnt - we0, {31'd0, VECS[v].exp_we});
            check($sformatf("R6 read strobes vec%0d", v), rd_cnt - rd0, {31'd0, VECS[v].exp_rd});
            check($sformatf("R3 ctrl_bits vec%0d", v), {26'd0, ctrl_bits}, {26'd0, VECS[v].exp_bits});
            if (VECS[v].instr[7:6] == 2'b10 && VECS[v].npulse == 5'd16)
                check($sformatf("R2 so word vec%0d", v), {16'd0, so_cap}, {16'd0, VECS[v].diag});
            if (VECS[v].instr[7:6] != 2'b10)
                check($sformatf("R5 so_oe released vec%0d", v), {31'd0, oe_late}, 32'd0);
            check($sformatf("R9 so_oe after frame vec%0d", v), {31'd0, so_oe}, 32'd0);
        end

        // R7: serial clock high at select fall (16 falling edges counted in total)
        we0 = we_cnt;
        run_frame(16'h040A, 15, 1'b1, 1'b0, 1'b0, -1);
        check("R7 high at select fall", we_cnt - we0, 32'd0);
        check("R7 bits kept", {26'd0, ctrl_bits}, 32'h3F);

        // R7: serial clock high at select rise
        we0 = we_cnt;
        run_frame(16'h8205, 16, 1'b0, 1'b1, 1'b0, -1);
        check("R7 high at select rise", we_cnt - we0, 32'd0);
        check("R7 bits kept rise", {26'd0, ctrl_bits}, 32'h3F);

        // R8: activity while select high is ignored
        we0 = we_cnt;
        rd0 = rd_cnt;
        for (int k = 0; k < 20; k++) begin
            si_in = k[0];
            sclk_in = 1'b1;
            repeat (HALF) @(negedge clk);
            check("R9 so_oe select high", {31'd0, so_oe}, 32'd0);
            sclk_in = 1'b0;
            repeat (HALF) @(negedge clk);
        end
        repeat (10) @(negedge clk);
        check("R8 no strobes", (we_cnt - we0) + (rd_cnt - rd0), 32'd0);
        check("R8 bits unchanged", {26'd0, ctrl_bits}, 32'h3F);

        // R4: sixteenth falling edge coincides with select release
        we0 = we_cnt;
        run_frame(16'h8205, 16, 1'b0, 1'b0, 1'b1, -1);
        check("R4 coincident edge", we_cnt - we0, 32'd0);
        check("R4 bits kept", {26'd0, ctrl_bits}, 32'h3F);

        // R1: reset in mid-frame discards the frame
        we0 = we_cnt;
        run_frame(16'h8205, 16, 1'b0, 1'b0, 1'b0, 7);
        check("R1 so_oe during reset", {31'd0, oe_in_rst}, 32'd0);
        check("R1 mid-frame reset no commit", we_cnt - we0, 32'd0);
        check("R1 bits cleared", {26'd0, ctrl_bits}, 32'd0);

        // R6: recovery with a clean write
        we0 = we_cnt;
        run_frame(16'h8215, 16, 1'b0, 1'b0, 1'b0, -1);
        check("R6 write after recovery", we_cnt - we0, 32'd1);
        check("R6 bits after recovery", {26'd0, ctrl_bits}, 32'h15);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule